// File: doc/BRIEF.md
# Interrupt Mask and Status Register Bank

This block is the interrupt control corner of a serial peripheral's register file. It keeps a per-source status word and a per-source mask word. Each bit of the status word is set by a one-cycle event pulse from the peripheral's datapath, and the host clears it by writing ones. The mask can never be written directly. The host sets bits through an enable address and clears them through a disable address. The mask's own address can only be read.

A single interrupt line is raised whenever a status bit and its mask bit are both set. A two-state machine drives this line: `IRQ_IDLE` moves to `IRQ_ACTIVE` when the next-cycle pending set is non-empty (transition `RAISE`). `IRQ_ACTIVE` returns to `IRQ_IDLE` when that set becomes empty (transition `DROP`). In every other case the machine stays where it is (transitions `HOLD_IDLE`, `HOLD_ACTIVE`).

The host addresses registers in bytes. The word index is the byte address shifted right by two. Indices at or beyond the register count are ignored. Indices that this bank does not own are left to other blocks.

Top module: `irqbank_top`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release, the mask, the status word, the interrupt output and the read data are all zero until the first event or write.
- R2: A write to word index 2 (byte 0x08) ORs wr_data[NUM_IRQ-1:0] into the mask. Mask bits that are already set stay set.
- R3: A write to word index 3 (byte 0x0C) clears every mask bit whose written bit is 1 and keeps the other mask bits.
- R4: A write to word index 4 (byte 0x10) leaves the mask unchanged. A read of index 4 returns the mask in bits [NUM_IRQ-1:0], with the upper bits zero.
- R5: A write to word index 5 (byte 0x14) clears each status bit whose written bit is 1 and keeps the others. A read of index 5 returns the status word zero-extended.
- R6: An event bit that is high for one cycle sets the matching status bit at the next clock edge. If the host clears that same bit in the same cycle, the set wins.
- R7: The word index is addr >> 2, so address bits [1:0] are ignored. A write whose index is NUM_REGS (default 8) or more changes neither the mask nor the status, even if its low index bits match an owned register.
- R8: Read data is registered. It is loaded on the clock edge where rd_en is high. Reads of indices 2, 3, any index not owned, and any out-of-range index return zero.
- R9: The interrupt output equals the OR over all bits of (status AND mask). It is registered, so it changes on the same clock edge as the register write or event that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe; loads rd_data at the edge |
| rd_data | output | DATA_W | Registered read data |
| evt | input | NUM_IRQ | Raw interrupt event pulses, one per source |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a host write-one-to-clear that lands in the same cycle as a new event on the same bit. Only then can a wrong priority lose an interrupt. The bench first sets a neighbouring status bit. It then drives an event pulse and a status write in a single cycle, with a clear pattern that covers both the pulsing bit and the neighbour. The read-back must show the pulsing bit kept and the neighbour cleared. Out-of-range writes are aimed at indices whose low bits alias the enable and status registers, so a truncated range check would be exposed.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    // Word indices owned by this bank; the order is fixed by the host map.
    localparam int IDX_ENABLE  = 2;
    localparam int IDX_DISABLE = 3;
    localparam int IDX_MASK    = 4;
    localparam int IDX_STATUS  = 5;

endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
    import irqbank_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic              hit_enable,
    output logic              hit_disable,
    output logic              hit_mask,
    output logic              hit_status
);
    localparam int IDX_W = ADDR_W;

    logic [IDX_W-1:0] word_idx;

    always_comb begin
        word_idx    = addr >> 2;
        in_range    = (int'(word_idx) < NUM_REGS);
        hit_enable  = in_range && (int'(word_idx) == IDX_ENABLE);
        hit_disable = in_range && (int'(word_idx) == IDX_DISABLE);
        hit_mask    = in_range && (int'(word_idx) == IDX_MASK);
        hit_status  = in_range && (int'(word_idx) == IDX_STATUS);
    end

endmodule

// File: rtl/irqbank_mask.sv
module irqbank_mask #(
    parameter int NUM_IRQ = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic [NUM_IRQ-1:0] bits,
    output logic [NUM_IRQ-1:0] mask_q,
    output logic [NUM_IRQ-1:0] mask_next
);
    always_comb begin
        mask_next = mask_q;
        if (set_stb) begin
            mask_next = mask_q | bits;
        end else if (clr_stb) begin
            mask_next = mask_q & ~bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_next;
        end
    end

endmodule

// File: rtl/irqbank_status.sv
module irqbank_status #(
    parameter int NUM_IRQ = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] evt,
    input  logic               clr_stb,
    input  logic [NUM_IRQ-1:0] bits,
    output logic [NUM_IRQ-1:0] status_q,
    output logic [NUM_IRQ-1:0] status_next
);
    logic [NUM_IRQ-1:0] clr_vec;

    always_comb begin
        clr_vec = clr_stb ? bits : '0;
    end

    // Per-bit update: a fresh event outranks a host clear.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        always_comb begin
            if (evt[i]) begin
                status_next[i] = 1'b1;
            end else if (clr_vec[i]) begin
                status_next[i] = 1'b0;
            end else begin
                status_next[i] = status_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_next;
        end
    end

endmodule

// File: rtl/irqbank_irq_fsm.sv
module irqbank_irq_fsm
    import irqbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_next,
    output logic irq
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending_next)  state_d = IRQ_ACTIVE; // RAISE
            IRQ_ACTIVE: if (!pending_next) state_d = IRQ_IDLE;   // DROP
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_ACTIVE);
    end

endmodule

// File: rtl/irqbank_top.sv
module irqbank_top #(
    parameter int NUM_IRQ  = 14,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_IRQ-1:0] evt,
    output logic               irq
);
    logic               in_range;
    logic               hit_enable, hit_disable, hit_mask, hit_status;
    logic [NUM_IRQ-1:0] wbits;
    logic [NUM_IRQ-1:0] mask_q, mask_next;
    logic [NUM_IRQ-1:0] status_q, status_next;
    logic               pending_next;
    logic [DATA_W-1:0]  rd_sel;
    logic [DATA_W-1:0]  rd_q;

    assign wbits = NUM_IRQ'(wr_data);

    irqbank_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_decode (
        .addr        (addr),
        .in_range    (in_range),
        .hit_enable  (hit_enable),
        .hit_disable (hit_disable),
        .hit_mask    (hit_mask),
        .hit_status  (hit_status)
    );

    irqbank_mask #(
        .NUM_IRQ (NUM_IRQ)
    ) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_stb   (wr_en && hit_enable),
        .clr_stb   (wr_en && hit_disable),
        .bits      (wbits),
        .mask_q    (mask_q),
        .mask_next (mask_next)
    );

    irqbank_status #(
        .NUM_IRQ (NUM_IRQ)
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .clr_stb     (wr_en && hit_status),
        .bits        (wbits),
        .status_q    (status_q),
        .status_next (status_next)
    );

    assign pending_next = |(status_next & mask_next);

    irqbank_irq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pending_next (pending_next),
        .irq          (irq)
    );

    always_comb begin
        rd_sel = '0;
        if (hit_mask) begin
            rd_sel = DATA_W'(mask_q);
        end else if (hit_status) begin
            rd_sel = DATA_W'(status_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_sel;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk
    import irqbank_pkg::*;
#(
    parameter int NUM_IRQ  = 14,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data,
    input logic [NUM_IRQ-1:0] evt,
    input logic [NUM_IRQ-1:0] mask,
    input logic [NUM_IRQ-1:0] status,
    input logic               irq
);
    logic [ADDR_W-1:0]  idx;
    logic               inr;
    logic [NUM_IRQ-1:0] wb;

    assign idx = addr >> 2;
    assign inr = int'(idx) < NUM_REGS;
    assign wb  = NUM_IRQ'(wr_data);

    AST_ENABLE_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inr && int'(idx) == IDX_ENABLE) |=> mask == ($past(mask) | $past(wb))); // R2

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inr && int'(idx) == IDX_DISABLE) |=> mask == ($past(mask) & ~$past(wb))); // R3

    AST_MASK_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inr && int'(idx) == IDX_MASK) |=> $stable(mask)); // R4

    AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inr && int'(idx) == IDX_STATUS && evt == '0)
        |=> status == ($past(status) & ~$past(wb))); // R5

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt))); // R6

    AST_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inr && evt == '0) |=> ($stable(mask) && $stable(status))); // R7

    AST_IRQ_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(status & mask)); // R9

endmodule

bind irqbank_top irqbank_chk #(
    .NUM_IRQ  (NUM_IRQ),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .evt     (evt),
    .mask    (mask_q),
    .status  (status_q),
    .irq     (irq)
);

// File: tb/sim_irqbank_top.sv
module sim_irqbank_top;
    localparam int N = 4;
    localparam logic [7:0] A_EN  = 8'h08;
    localparam logic [7:0] A_DIS = 8'h0C;
    localparam logic [7:0] A_MSK = 8'h10;
    localparam logic [7:0] A_STS = 8'h14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic         rd_en = 1'b0;
    logic [31:0]  rd_data;
    logic [N-1:0] evt = '0;
    logic         irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    irqbank_top #(.NUM_IRQ(N), .ADDR_W(8), .DATA_W(32), .NUM_REGS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .evt(evt), .irq(irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <150000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic pulse(input logic [N-1:0] v);
        evt = v;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        chk("R1 rd_data in reset", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_MSK, v); chk("R1 mask after reset", v, 32'h0);
        rd(A_STS, v); chk("R1 status after reset", v, 32'h0);

        // Exhaustive mask x event sweep
        for (int m = 0; m < 16; m++) begin
            for (int s = 0; s < 16; s++) begin
                wr(A_DIS, 32'hF);
                wr(A_STS, 32'hF);
                wr(A_EN, 32'(m));
                pulse(N'(s));
                chk("R9 irq after event", {31'b0, irq}, {31'b0, |(m & s)});
                rd(A_MSK, v); chk("R2 mask after enable", v, 32'(m));
                rd(A_STS, v); chk("R6 status after event", v, 32'(s));
                wr(A_STS, 32'(s));
                chk("R9 irq after clear", {31'b0, irq}, 32'h0);
            end
        end

        // Enable ORs into existing mask
        wr(A_DIS, 32'hF); wr(A_EN, 32'h3); wr(A_EN, 32'h4);
        rd(A_MSK, v); chk("R2 enable keeps bits", v, 32'h7);

        // Disable sweep
        for (int d = 0; d < 16; d++) begin
            wr(A_EN, 32'hF);
            wr(A_DIS, 32'(d));
            rd(A_MSK, v); chk("R3 mask after disable", v, 32'(4'hF & ~4'(d)));
        end

        // W1C sweep
        for (int c = 0; c < 16; c++) begin
            pulse(4'hF);
            wr(A_STS, 32'(c));
            rd(A_STS, v); chk("R5 status after w1c", v, 32'(4'hF & ~4'(c)));
        end
        wr(A_STS, 32'hF);

        // Mask address read-only
        wr(A_DIS, 32'hF); wr(A_EN, 32'h5); wr(A_MSK, 32'hA);
        rd(A_MSK, v); chk("R4 mask write ignored", v, 32'h5);

        // Same-cycle set and clear
        pulse(4'h2);
        evt = 4'h1; addr = A_STS; wr_data = 32'h3; wr_en = 1'b1;
        @(negedge clk);
        evt = '0; wr_en = 1'b0;
        rd(A_STS, v); chk("R6 set wins over clear", v, 32'h1);

        // Out-of-range writes aliasing owned indices
        wr(8'h28, 32'hF);
        wr(8'h2C, 32'hF);
        wr(8'h34, 32'hF);
        wr(8'hFC, 32'hF);
        rd(A_MSK, v); chk("R7 out-of-range mask", v, 32'h5);
        rd(A_STS, v); chk("R7 out-of-range status", v, 32'h1);

        // Low address bits ignored
        wr(8'h0B, 32'h8);
        rd(8'h13, v); chk("R7 index from addr>>2", v, 32'hD);

        // Zero reads
        rd(A_EN, v);  chk("R8 read enable addr", v, 32'h0);
        rd(A_DIS, v); chk("R8 read disable addr", v, 32'h0);
        rd(8'h00, v); chk("R8 read unowned addr", v, 32'h0);
        rd(8'h34, v); chk("R8 read out-of-range", v, 32'h0);

        // irq follows mask change
        chk("R9 irq with status1 mask bit0", {31'b0, irq}, 32'h1);
        wr(A_DIS, 32'h1);
        chk("R9 irq drops on disable", {31'b0, irq}, 32'h0);
        wr(A_EN, 32'h1);
        chk("R9 irq rises on enable", {31'b0, irq}, 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule